// File: doc/BRIEF.md
# Prioritized Eight-Source Interrupt Controller

This block gathers interrupt requests for a small 16-bit processor core and decides which one, if any, the core should take. Five internal event lines cover the PWM timer, two general timers, the real-time-clock timer and a program-counter stack-overflow trap. Two external pins, taken from bits 6 and 7 of port A, are synchronized and edge-detected. Each event is latched into a pending register. Pending bits are then gated by per-source enables and by a global enable, and a fixed priority picks the winner. The controller drives the winner's 3-bit vector index beside an interrupt-request line.

Software reaches the controller through a byte-wide register port with a combinational read path. One register is shared: it holds the global enable in its top bit and the processor's arithmetic flags in its low nibble. When the core accepts an interrupt, it pulses an acknowledge. On that cycle the controller clears the global enable and the serviced pending bit, so nested entry stays off until software turns it back on.

Top module: `irq_ctrl`

## Requirements
- R1: After reset, the registers at addresses 0, 1 and 2 all read 0x00, and `irq_o` is low.
- R2: Address 0 holds the global enable in bit 7 and four flags in bits 3..0, and bits 6..4 always read 0. Address 1 holds the enables, with bit n enabling slot n. Address 2 holds the pending requests, with bit n for slot n. Address 3 reads 0x00. A write updates the addressed register at the clock edge.
- R3: Internal event bit n high at a clock edge sets pending bit n. This happens whatever the enables and the global enable hold. The event lines used are bits 0, 1, 2, 3 and 7; bits 4, 5 and 6 of `int_evt_i` are ignored.
- R4: Writing address 2 loads the pending register, so a 0 clears a bit and a 1 sets it. A hardware set in the same cycle wins over a written 0.
- R5: Pending bit 6 is a reserved slot and always reads 0, even after events or writes that target it.
- R6: While the global enable is 0, `irq_o` stays low whatever the enables and pending bits hold.
- R7: `irq_o` is high exactly when the global enable is 1 and at least one slot is both pending and enabled.
- R8: When several enabled slots are pending, `irq_vec_o` gives the lowest such slot number (0..7).
- R9: A rising edge on `ext_pin_i[0]` sets pending bit 4, and one on `ext_pin_i[1]` sets bit 5. The bit becomes visible after the third clock edge that follows the change. A level held high sets the bit only once, and a falling edge sets nothing.
- R10: `ack_i` high while `irq_o` is high clears, at that clock edge, the global enable and the pending bit of the slot shown on `irq_vec_o`. Other bits are kept, and a same-cycle status write does not keep the enable on. `ack_i` while `irq_o` is low has no effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_addr_i | input | 2 | Register address |
| reg_wr_i | input | 1 | Write strobe |
| reg_wdata_i | input | 8 | Write data |
| reg_rdata_o | output | 8 | Read data for `reg_addr_i` (combinational) |
| int_evt_i | input | 8 | Internal event lines, bit n for slot n |
| ext_pin_i | input | 2 | External pins (port A bits 6 and 7) |
| ack_i | input | 1 | Core acknowledge of the current interrupt |
| irq_o | output | 1 | Interrupt request to the core |
| irq_vec_o | output | 3 | Vector index of the winning slot |

## Verification
Directed sequences cover several cases: a single pending slot with its enable off and then on, the global enable toggled while requests wait, and all enables set with several slots pending at once. Together these separate enable gating from priority order. Pin sequences with a short pulse, a long held level and a falling edge separate true edge capture from level sensing, and they pin down the three-edge latency. Constrained-random mixes of writes, events, pin toggles and acknowledges expose collisions that directed cases miss: a same-cycle hardware set against a software clear, and an acknowledge against a status write.

// File: rtl/irq_pkg.sv
package irq_pkg;
    localparam int unsigned NSRC      = 8;
    localparam int unsigned VEC_W     = $clog2(NSRC);
    localparam int unsigned DATA_W    = 8;
    localparam int unsigned ADDR_W    = 2;
    localparam int unsigned NEXT      = 2;
    localparam int unsigned FLAG_W    = 4;

    localparam int unsigned SLOT_EXT0 = 4;
    localparam int unsigned SLOT_EXT1 = 5;
    localparam int unsigned SLOT_RSVD = 6;

    // internal event lines that may set a request
    localparam logic [NSRC-1:0] INT_EVT_MASK = 8'b1000_1111;
    // slots that can ever hold a pending bit
    localparam logic [NSRC-1:0] REQ_KEEP_MASK = ~(8'(1) << SLOT_RSVD);

    localparam logic [ADDR_W-1:0] A_STAT = 2'd0;
    localparam logic [ADDR_W-1:0] A_ENA  = 2'd1;
    localparam logic [ADDR_W-1:0] A_REQ  = 2'd2;

    typedef struct packed {
        logic              gie;
        logic [FLAG_W-1:0] flags;
        logic [NSRC-1:0]   ena;
        logic [NSRC-1:0]   req;
    } ctl_t;
endpackage

// File: rtl/irq_edge_sync.sv
module irq_edge_sync #(
    parameter int unsigned W = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] pin_i,
    output logic [W-1:0] rise_o
);
    typedef struct packed {
        logic [W-1:0] s1;
        logic [W-1:0] s2;
        logic [W-1:0] s3;
    } sync_t;

    sync_t sync_d, sync_q;

    always_comb begin
        sync_d    = sync_q;
        sync_d.s1 = pin_i;
        sync_d.s2 = sync_q.s1;
        sync_d.s3 = sync_q.s2;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sync_q <= '0;
        else        sync_q <= sync_d;
    end

    assign rise_o = sync_q.s2 & ~sync_q.s3;

    // R9: a held level produces a single-cycle rise
    a_r9_single_rise: assert property (@(posedge clk) disable iff (!rst_n)
        (|rise_o) |=> ((rise_o & $past(rise_o)) == '0));
endmodule

// File: rtl/irq_prio_enc.sv
module irq_prio_enc #(
    parameter int unsigned N     = 8,
    parameter int unsigned VEC_W = $clog2(N)
) (
    input  logic [N-1:0]     pend_i,
    output logic             any_o,
    output logic [VEC_W-1:0] vec_o
);
    always_comb begin
        vec_o = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (pend_i[i]) vec_o = i[VEC_W-1:0];
        end
        any_o = |pend_i;
    end
endmodule

// File: rtl/irq_ctrl.sv
module irq_ctrl
    import irq_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [ADDR_W-1:0]    reg_addr_i,
    input  logic                 reg_wr_i,
    input  logic [DATA_W-1:0]    reg_wdata_i,
    output logic [DATA_W-1:0]    reg_rdata_o,
    input  logic [NSRC-1:0]      int_evt_i,
    input  logic [NEXT-1:0]      ext_pin_i,
    input  logic                 ack_i,
    output logic                 irq_o,
    output logic [VEC_W-1:0]     irq_vec_o
);
    localparam int unsigned PAD_W = DATA_W - 1 - FLAG_W;

    ctl_t ctl_d, ctl_q;

    logic [NEXT-1:0] ext_rise;
    logic [NSRC-1:0] hw_set;
    logic [NSRC-1:0] pend;
    logic            pend_any;
    logic [VEC_W-1:0] win_vec;
    logic            take;

    irq_edge_sync #(.W(NEXT)) i_sync (
        .clk    (clk),
        .rst_n  (rst_n),
        .pin_i  (ext_pin_i),
        .rise_o (ext_rise)
    );

    always_comb begin
        hw_set = int_evt_i & INT_EVT_MASK;
        hw_set[SLOT_EXT0] = ext_rise[0];
        hw_set[SLOT_EXT1] = ext_rise[1];
    end

    assign pend = ctl_q.req & ctl_q.ena;

    irq_prio_enc #(.N(NSRC), .VEC_W(VEC_W)) i_prio (
        .pend_i (pend),
        .any_o  (pend_any),
        .vec_o  (win_vec)
    );

    assign irq_o     = ctl_q.gie & pend_any;
    assign irq_vec_o = win_vec;
    assign take      = ack_i & irq_o;

    always_comb begin
        ctl_d = ctl_q;
        if (reg_wr_i) begin
            case (reg_addr_i)
                A_STAT: begin
                    ctl_d.gie   = reg_wdata_i[DATA_W-1];
                    ctl_d.flags = reg_wdata_i[FLAG_W-1:0];
                end
                A_ENA:   ctl_d.ena = reg_wdata_i;
                A_REQ:   ctl_d.req = reg_wdata_i;
                default: ;
            endcase
        end
        if (take) begin
            ctl_d.gie          = 1'b0;
            ctl_d.req[win_vec] = 1'b0;
        end
        ctl_d.req = (ctl_d.req | hw_set) & REQ_KEEP_MASK;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ctl_q <= '0;
        else        ctl_q <= ctl_d;
    end

    always_comb begin
        case (reg_addr_i)
            A_STAT:  reg_rdata_o = {ctl_q.gie, {PAD_W{1'b0}}, ctl_q.flags};
            A_ENA:   reg_rdata_o = ctl_q.ena;
            A_REQ:   reg_rdata_o = ctl_q.req;
            default: reg_rdata_o = '0;
        endcase
    end

    // R6: no request to the core while globally disabled
    a_r6_gie_gates_irq: assert property (@(posedge clk) disable iff (!rst_n)
        !ctl_q.gie |-> !irq_o);

    // R8: the shown vector is pending+enabled and no lower slot is
    a_r8_lowest_wins: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o |-> (pend[irq_vec_o] &&
                   ((pend & ((8'(1) << irq_vec_o) - 8'(1))) == '0)));

    // R10: acknowledge closes the global enable on the next cycle
    a_r10_ack_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_i && irq_o) |=> !ctl_q.gie);

    // R4: a hardware set is never lost, even against a clear
    a_r4_hw_wins: assert property (@(posedge clk) disable iff (!rst_n)
        (|hw_set) |=> ((ctl_q.req & $past(hw_set)) == $past(hw_set)));
endmodule

// File: tb/test_irq_ctrl.sv
`timescale 1ns/1ps
module test_irq_ctrl;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [1:0] addr = '0;
    logic       wr = 1'b0;
    logic [7:0] wd = '0;
    logic [7:0] rd;
    logic [7:0] evt = '0;
    logic [1:0] pin = '0;
    logic       ack = 1'b0;
    logic       irq;
    logic [2:0] vec;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    // bench model
    logic       m_gie;
    logic [3:0] m_flags;
    logic [7:0] m_ena, m_req;
    logic [1:0] m_s1, m_s2, m_s3;

    always #4 clk = ~clk;

    irq_ctrl i_irq_ctrl (
        .clk(clk), .rst_n(rst_n), .reg_addr_i(addr), .reg_wr_i(wr),
        .reg_wdata_i(wd), .reg_rdata_o(rd), .int_evt_i(evt),
        .ext_pin_i(pin), .ack_i(ack), .irq_o(irq), .irq_vec_o(vec)
    );

    function automatic logic exp_irq();
        return m_gie && ((m_req & m_ena) != 8'h00);
    endfunction

    function automatic logic [2:0] exp_vec();
        logic [7:0] p = m_req & m_ena;
        for (int i = 0; i < 8; i++) if (p[i]) return 3'(i);
        return 3'd0;
    endfunction

    function automatic logic [7:0] exp_rd(input logic [1:0] a);
        case (a)
            2'd0: return {m_gie, 3'b000, m_flags};
            2'd1: return m_ena;
            2'd2: return m_req;
            default: return 8'h00;
        endcase
    endfunction

    task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // one clock: drive inputs, check pre-edge outputs, advance model
    task automatic cycle(input logic w, input logic [1:0] a, input logic [7:0] d,
                         input logic [7:0] e, input logic [1:0] p, input logic k);
        logic [1:0] rise;
        logic [7:0] hw, nreq;
        logic       take;
        wr = w; addr = a; wd = d; evt = e; pin = p; ack = k;
        #1;
        chk("R2 read data", rd, exp_rd(a));
        chk("R7 irq level", {7'b0, irq}, {7'b0, exp_irq()});
        if (exp_irq()) chk("R8 vector", {5'b0, vec}, {5'b0, exp_vec()});
        take = k && exp_irq();
        rise = m_s2 & ~m_s3;
        hw   = (e & 8'h8F) | {2'b00, rise, 4'b0000};
        nreq = (w && a == 2'd2) ? d : m_req;
        if (take) nreq[exp_vec()] = 1'b0;
        nreq = (nreq | hw) & 8'hBF;
        if (w && a == 2'd0) begin m_gie = d[7]; m_flags = d[3:0]; end
        if (w && a == 2'd1) m_ena = d;
        if (take) m_gie = 1'b0;
        m_req = nreq;
        m_s3 = m_s2; m_s2 = m_s1; m_s1 = p;
        @(posedge clk);
        @(negedge clk);
        wr = 1'b0; evt = '0; ack = 1'b0;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) cycle(1'b0, 2'd3, 8'h00, 8'h00, pin, 1'b0);
    endtask

    task automatic peek(input string tag, input logic [1:0] a, input logic [7:0] exp);
        wr = 1'b0; addr = a;
        #1;
        chk(tag, rd, exp);
    endtask

    initial begin
        #1_000_000;
        if (!done) begin
            fails++;
            checks++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h5EED_0042));
        m_gie = 0; m_flags = 0; m_ena = 0; m_req = 0; m_s1 = 0; m_s2 = 0; m_s3 = 0;
        repeat (3) @(negedge clk);
        // R1: reset state
        peek("R1 status reset", 2'd0, 8'h00);
        peek("R1 enable reset", 2'd1, 8'h00);
        peek("R1 request reset", 2'd2, 8'h00);
        chk("R1 irq reset", {7'b0, irq}, 8'h00);
        rst_n = 1'b1;
        @(negedge clk);

        // R2: status bits 6..4 read zero, address 3 zero
        cycle(1'b1, 2'd0, 8'h7F, 8'h00, 2'b00, 1'b0);
        peek("R2 status pad bits", 2'd0, 8'h0F);
        peek("R2 addr3 zero", 2'd3, 8'h00);
        cycle(1'b1, 2'd0, 8'h00, 8'h00, 2'b00, 1'b0);

        // R3: latch while disabled; masked event lines ignored
        cycle(1'b0, 2'd3, 8'h00, 8'h74, 2'b00, 1'b0);
        peek("R3 latch with enables off", 2'd2, 8'h04);
        chk("R6 irq off with gie=0", {7'b0, irq}, 8'h00);

        // R4: clear by write; hw set wins over clear
        cycle(1'b1, 2'd2, 8'h00, 8'h01, 2'b00, 1'b0);
        peek("R4 hw set beats clear", 2'd2, 8'h01);
        cycle(1'b1, 2'd2, 8'h00, 8'h00, 2'b00, 1'b0);
        peek("R4 write clears", 2'd2, 8'h00);

        // R5: reserved slot never pends
        cycle(1'b1, 2'd2, 8'hFF, 8'h40, 2'b00, 1'b0);
        peek("R5 slot6 stays clear", 2'd2, 8'hBF);

        // R6: enables on, gie off -> no irq
        cycle(1'b1, 2'd1, 8'hFF, 8'h00, 2'b00, 1'b0);
        chk("R6 gie gates all", {7'b0, irq}, 8'h00);

        // R8/R10: gie on, priority and acknowledge
        cycle(1'b1, 2'd0, 8'h80, 8'h00, 2'b00, 1'b0);
        chk("R7 irq raised", {7'b0, irq}, 8'h01);
        chk("R8 lowest slot", {5'b0, vec}, 8'h00);
        cycle(1'b1, 2'd0, 8'h80, 8'h00, 2'b00, 1'b1);
        peek("R10 ack clears gie", 2'd0, 8'h00);
        peek("R10 ack clears slot0 only", 2'd2, 8'hBE);
        cycle(1'b0, 2'd3, 8'h00, 8'h00, 2'b00, 1'b1);
        peek("R10 ack ignored without irq", 2'd2, 8'hBE);
        cycle(1'b1, 2'd1, 8'h30, 8'h00, 2'b00, 1'b0);
        cycle(1'b1, 2'd0, 8'h80, 8'h00, 2'b00, 1'b0);
        chk("R8 vector among 4,5", {5'b0, vec}, 8'h04);
        cycle(1'b1, 2'd2, 8'h00, 8'h00, 2'b00, 1'b0);

        // R9: external edge latency and single capture
        cycle(1'b0, 2'd3, 8'h00, 8'h00, 2'b01, 1'b0);
        cycle(1'b0, 2'd3, 8'h00, 8'h00, 2'b01, 1'b0);
        peek("R9 not yet after two edges", 2'd2, 8'h00);
        cycle(1'b0, 2'd3, 8'h00, 8'h00, 2'b01, 1'b0);
        peek("R9 set after third edge", 2'd2, 8'h10);
        cycle(1'b1, 2'd2, 8'h00, 8'h00, 2'b01, 1'b0);
        idle(4);
        peek("R9 held level sets once", 2'd2, 8'h00);
        cycle(1'b0, 2'd3, 8'h00, 8'h00, 2'b00, 1'b0);
        idle(4);
        peek("R9 falling edge ignored", 2'd2, 8'h00);
        cycle(1'b0, 2'd3, 8'h00, 8'h00, 2'b10, 1'b0);
        idle(3);
        peek("R9 pin1 to slot5", 2'd2, 8'h20);

        // constrained random
        for (int n = 0; n < 4000; n++) begin
            logic       w = ($urandom % 4) == 0;
            logic [1:0] a = 2'($urandom % 4);
            logic [7:0] d = 8'($urandom);
            logic [7:0] e = (($urandom % 6) == 0) ? 8'(1 << ($urandom % 8)) : 8'h00;
            logic [1:0] p = (($urandom % 5) == 0) ? 2'($urandom) : pin;
            logic       k = ($urandom % 5) == 0;
            if (w && a == 2'd0 && ($urandom % 2) == 0) d[7] = 1'b1;
            cycle(w, a, d, e, p, k);
        end

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule